// File: doc/BRIEF.md
# Dual-Clock Write Register File

This block is a small register array that two unrelated clock domains can both write. No request crosses from one domain to the other, and no fast shared clock is needed. Each write side decodes its address into one enable per element. It captures those enables, together with its write data, on the falling edge of its own clock. Every element owns a write strobe, which is the OR of the two registered enables for that element. That strobe is the only clock the element sees. A write therefore lands even when the other side's clock has stopped or runs at any ratio to this one.

Each side also has a combinational read port, so the stored words can be read with no clock running. The write request behaves as a stream valid whose ready is always high. Each falling edge with the request high is one accepted write, and there is no back-pressure.

Software must not write the same element from both sides while the two enables overlap. If it does, the element keeps port A's data. Two requests in a row from one side to the same element make a single strobe edge, so only the first of them is stored.

Top module: `dual_wr_regfile`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every element reads 0 on both read ports. Asserting `rst_n` again at any time returns every element to 0.
- R2: Each side decodes its address before the falling-edge register. After any falling edge of its clock, at most one of that side's registered element enables is high.
- R3: Suppose `a_we` is high at a falling edge of `a_clk`. Then the element at `a_waddr` becomes enabled and takes `a_wdata`, which both read ports return before the next rising edge of `a_clk`.
- R4: Suppose `b_we` is high at a falling edge of `b_clk`. Then the element at `b_waddr` becomes enabled and takes `b_wdata`, even if `a_clk` is held still.
- R5: A falling edge with the write request low enables no element. No element changes, whatever the address and data inputs carry.
- R6: `a_rdata` and `b_rdata` return the element selected by `a_raddr` and `b_raddr` combinationally, with no clock involved.
- R7: Suppose one side requests the same element at two falling edges in a row, with no idle edge between them. Then the strobe rises only once, and the element keeps the data from the first request.
- R8: Writes from the two sides to different elements may overlap in time, and each element ends up holding the data of its own side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the enables, data registers and elements |
| a_clk | input | 1 | Clock of write side A; the falling edge is used |
| a_we | input | 1 | Side A write request (valid; always accepted) |
| a_waddr | input | ADDR_W | Side A element index |
| a_wdata | input | DATA_W | Side A write word |
| a_raddr | input | ADDR_W | Read index of read port A |
| a_rdata | output | DATA_W | Combinational read data of port A |
| b_clk | input | 1 | Clock of write side B; the falling edge is used |
| b_we | input | 1 | Side B write request (valid; always accepted) |
| b_waddr | input | ADDR_W | Side B element index |
| b_wdata | input | DATA_W | Side B write word |
| b_raddr | input | ADDR_W | Read index of read port B |
| b_rdata | output | DATA_W | Combinational read data of port B |

## Verification
The properties assume three things about the inputs. Each side's request and address are stable around that side's falling edge. Address values stay below the depth. The two sides never enable the same element at the same time. The stimulus changes every input one time unit after a rising edge, so it stays far from the falling edge that samples it. It draws addresses only from the valid range. In overlapping traffic it gives the two sides disjoint elements. It leaves an idle falling edge between repeat writes to one element, except in the test that targets the merge case on purpose. One test stops side A's clock while side B writes. This shows that the strobe alone carries the write.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_DEPTH  = 16;

  // Which write side an element's strobe edge belongs to
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} wr_src_e;

  function automatic wr_src_e pick_src(input logic en_a);
    return en_a ? SRC_A : SRC_B;
  endfunction
endpackage

// File: rtl/dwrf_wr_port.sv
module dwrf_wr_port #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DEPTH-1:0]  en_q,
  output logic [DATA_W-1:0] data_q
);
  logic [DEPTH-1:0] en_d;

  // Decode ahead of the register so each enable leaves a flop cleanly
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign en_d[i] = req && (addr == ADDR_W'(i));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      data_q <= '0;
    end else begin
      en_q   <= en_d;
      data_q <= data;
    end
  end
endmodule

// File: rtl/dwrf_cell.sv
module dwrf_cell
  import dwrf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rst_n,
  input  logic              en_a,
  input  logic              en_b,
  input  logic [DATA_W-1:0] data_a,
  input  logic [DATA_W-1:0] data_b,
  output logic [DATA_W-1:0] q
);
  logic strobe;
  assign strobe = en_a | en_b;

  always_ff @(posedge strobe or negedge rst_n) begin
    if (!rst_n)                   q <= '0;
    else if (pick_src(en_a) == SRC_A) q <= data_a;
    else                          q <= data_b;
  end
endmodule

// File: rtl/dwrf_rd_mux.sv
module dwrf_rd_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] store,
  input  logic [ADDR_W-1:0]            raddr,
  output logic [DATA_W-1:0]            rdata
);
  if (DEPTH == (1 << ADDR_W)) begin : g_full
    assign rdata = store[raddr];
  end else begin : g_part
    always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
        if (raddr == ADDR_W'(i)) rdata = store[i];
    end
  end
endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile
  import dwrf_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_clk,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_waddr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [ADDR_W-1:0] b_raddr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DEPTH-1:0]             en_a, en_b;
  logic [DATA_W-1:0]            dq_a, dq_b;
  logic [DEPTH-1:0][DATA_W-1:0] store;

  dwrf_wr_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_port_a (
    .clk(a_clk), .rst_n(rst_n), .req(a_we), .addr(a_waddr), .data(a_wdata),
    .en_q(en_a), .data_q(dq_a)
  );

  dwrf_wr_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_port_b (
    .clk(b_clk), .rst_n(rst_n), .req(b_we), .addr(b_waddr), .data(b_wdata),
    .en_q(en_b), .data_q(dq_b)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    dwrf_cell #(.DATA_W(DATA_W)) u_cell (
      .rst_n(rst_n), .en_a(en_a[i]), .en_b(en_b[i]),
      .data_a(dq_a), .data_b(dq_b), .q(store[i])
    );
  end

  dwrf_rd_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd_a (
    .store(store), .raddr(a_raddr), .rdata(a_rdata)
  );

  dwrf_rd_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd_b (
    .store(store), .raddr(b_raddr), .rdata(b_rdata)
  );
endmodule

// File: rtl/dwrf_checker.sv
module dwrf_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              rst_n,
  input logic              a_clk,
  input logic              b_clk,
  input logic              a_we,
  input logic              b_we,
  input logic [ADDR_W-1:0] a_waddr,
  input logic [ADDR_W-1:0] b_waddr,
  input logic [DEPTH-1:0]  en_a,
  input logic [DEPTH-1:0]  en_b
);
  // R2: one element per side at most
  a_r2_a_en_onehot: assert property (@(posedge a_clk) disable iff (!rst_n)
    $onehot0(en_a));
  a_r2_b_en_onehot: assert property (@(posedge b_clk) disable iff (!rst_n)
    $onehot0(en_b));

  // R3: a side-A request enables its addressed element
  a_r3_a_en_follows_req: assert property (@(negedge a_clk) disable iff (!rst_n)
    a_we |=> en_a[$past(a_waddr)]);

  // R4: a side-B request enables its addressed element
  a_r4_b_en_follows_req: assert property (@(negedge b_clk) disable iff (!rst_n)
    b_we |=> en_b[$past(b_waddr)]);

  // R5: no request, no enable
  a_r5_a_idle_no_en: assert property (@(negedge a_clk) disable iff (!rst_n)
    !a_we |=> (en_a == '0));
  a_r5_b_idle_no_en: assert property (@(negedge b_clk) disable iff (!rst_n)
    !b_we |=> (en_b == '0));
endmodule

bind dual_wr_regfile dwrf_checker #(.DEPTH(DEPTH)) u_dwrf_chk (
  .rst_n(rst_n), .a_clk(a_clk), .b_clk(b_clk), .a_we(a_we), .b_we(b_we),
  .a_waddr(a_waddr), .b_waddr(b_waddr), .en_a(en_a), .en_b(en_b)
);

// File: tb/tb_dual_wr_regfile.sv
`timescale 1ns/1ps
module tb_dual_wr_regfile;
  localparam int DW = 8;
  localparam int DP = 16;
  localparam int AW = 4;

  logic rst_n = 1'b0;
  logic a_clk = 1'b0, b_clk = 1'b0;
  logic a_run = 1'b1, b_run = 1'b1;
  logic a_we = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_waddr = '0, b_waddr = '0, a_raddr = '0, b_raddr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [DP];

  always #4   if (a_run) a_clk = ~a_clk;
  always #5.7 if (b_run) b_clk = ~b_clk;

  dual_wr_regfile #(.DATA_W(DW), .DEPTH(DP)) dut (
    .rst_n(rst_n), .a_clk(a_clk), .a_we(a_we), .a_waddr(a_waddr),
    .a_wdata(a_wdata), .a_raddr(a_raddr), .a_rdata(a_rdata),
    .b_clk(b_clk), .b_we(b_we), .b_waddr(b_waddr), .b_wdata(b_wdata),
    .b_raddr(b_raddr), .b_rdata(b_rdata)
  );

  // {side(0=A,1=B), addr, data}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 4'd0,  8'h11}, {1'b1, 4'd1,  8'h22}, {1'b0, 4'd2,  8'h3C},
    {1'b1, 4'd15, 8'hF0}, {1'b0, 4'd7,  8'h80}, {1'b1, 4'd8,  8'h01},
    {1'b0, 4'd9,  8'hFF}, {1'b1, 4'd14, 8'h5A}, {1'b0, 4'd1,  8'hA5},
    {1'b1, 4'd0,  8'h96}, {1'b0, 4'd4,  8'h42}, {1'b1, 4'd11, 8'h7E}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_both(input string req, input int addr, input logic [DW-1:0] exp);
    a_raddr = AW'(addr); b_raddr = AW'(addr);
    #1;
    check(req, a_rdata, exp);
    check(req, b_rdata, exp);
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < DP; i++) read_both(req, i, model[i]);
  endtask

  task automatic wr_a(input int addr, input logic [DW-1:0] d);
    @(posedge a_clk); #1;
    a_we = 1'b1; a_waddr = AW'(addr); a_wdata = d;
    @(posedge a_clk); #1;
    a_we = 1'b0; a_wdata = ~d;
    model[addr] = d;
  endtask

  task automatic wr_b(input int addr, input logic [DW-1:0] d);
    @(posedge b_clk); #1;
    b_we = 1'b1; b_waddr = AW'(addr); b_wdata = d;
    @(posedge b_clk); #1;
    b_we = 1'b0; b_wdata = ~d;
    model[addr] = d;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < DP; i++) model[i] = '0;
    // R1: contents during and after reset
    #20;
    read_both("R1", 0, 8'h00);
    read_both("R1", 9, 8'h00);
    rst_n = 1'b1;
    verify_all("R1");

    // R3/R4: table of single writes, checked after each
    for (int v = 0; v < 12; v++) begin
      if (VEC[v][12] == 1'b0) wr_a(int'(VEC[v][11:8]), VEC[v][7:0]);
      else                    wr_b(int'(VEC[v][11:8]), VEC[v][7:0]);
      read_both(VEC[v][12] ? "R4" : "R3", int'(VEC[v][11:8]), VEC[v][7:0]);
    end
    verify_all("R6");

    // R3: side A value visible before the next rising edge
    @(posedge a_clk); #1;
    a_we = 1'b1; a_waddr = 4'd5; a_wdata = 8'hC3;
    @(negedge a_clk); #1;
    a_we = 1'b0;
    model[5] = 8'hC3;
    read_both("R3", 5, 8'hC3);

    // R6: read index sweep, both ports on different elements
    for (int i = 0; i < DP; i++) begin
      a_raddr = AW'(i); b_raddr = AW'(DP - 1 - i);
      #1;
      check("R6", a_rdata, model[i]);
      check("R6", b_rdata, model[DP - 1 - i]);
    end

    // R5: idle requests with busy address/data lines change nothing
    for (int k = 0; k < 6; k++) begin
      @(posedge a_clk); #1;
      a_waddr = AW'(k); a_wdata = 8'hEE; b_waddr = AW'(k + 6); b_wdata = 8'hDD;
    end
    repeat (3) @(posedge b_clk);
    verify_all("R5");

    // R8: overlapping writes from both sides to disjoint elements
    for (int k = 0; k < 4; k++) begin
      fork
        wr_a(k, 8'(8'h30 + k));
        wr_b(k + 8, 8'(8'hB0 + k));
      join
    end
    verify_all("R8");

    // R4: side A clock held still while side B writes
    @(negedge a_clk); a_run = 1'b0;
    wr_b(6, 8'h6D);
    wr_b(13, 8'hD6);
    read_both("R4", 6, 8'h6D);
    read_both("R4", 13, 8'hD6);
    a_run = 1'b1;

    // R7: back-to-back request to one element keeps the first word
    repeat (2) @(posedge a_clk);
    #1; a_we = 1'b1; a_waddr = 4'd10; a_wdata = 8'h1F;
    @(posedge a_clk); #1; a_wdata = 8'h2E;
    @(posedge a_clk); #1; a_we = 1'b0;
    model[10] = 8'h1F;
    repeat (2) @(posedge a_clk);
    read_both("R7", 10, 8'h1F);
    @(posedge b_clk); #1; b_we = 1'b1; b_waddr = 4'd12; b_wdata = 8'h44;
    @(posedge b_clk); #1; b_wdata = 8'h55;
    @(posedge b_clk); #1; b_we = 1'b0;
    model[12] = 8'h44;
    repeat (2) @(posedge b_clk);
    read_both("R7", 12, 8'h44);

    // R1: reset asserted again mid-run clears every element
    #3 rst_n = 1'b0;
    #2;
    for (int i = 0; i < DP; i++) model[i] = '0;
    verify_all("R1");
    @(posedge a_clk); #1 rst_n = 1'b1;
    wr_a(3, 8'h99);
    read_both("R3", 3, 8'h99);

    summary();
  end
endmodule